// File: doc/BRIEF.md
# Timer Capture/Compare Channel Unit

This block wraps a free-running 16-bit timer counter with a set of timing channels. Dedicated capture channels watch an input pin each and, on the chosen transition, store the counter value and raise a flag. Dedicated compare channels each hold a match value and, when the running counter reaches it, raise a flag and act on their output pin by toggling it or driving it low or high. One further channel shares a single register and a single pin pair between the two roles. A control bit selects whether it captures from its input or compares and drives its output.

Software reaches every register through a simple word-wide bus. A write takes effect at the clock edge on which it is presented. Read data is registered and shows the addressed register one clock after the address is applied. Flags are cleared by writing ones to them.

Top module: `tmr_ccu`

## Requirements
- R1: After reset the counter is 0, every capture and compare register (dedicated and shared) reads 0xFFFF, the flag register reads 0, the compare pins are low, and the shared channel is in compare mode with `sh_oe` high.
- R2: The counter (address 0) advances by exactly one on every clock while the run bit (control register, address 1, bit 0) is 1. It holds while that bit is 0. Bus writes to address 0 have no effect.
- R3: When the counter advances from 0xFFFF it becomes 0x0000 and flag bit 15 is set.
- R4: Each capture channel k has a 2-bit edge field at bits [2k+1:2k] of address 2, coded 00 off, 01 rising, 10 falling, 11 either. The pin passes through two synchronizing flops. On a selected transition the channel's register (address 8+k) loads the counter value and flag bit k is set. Other transitions change neither.
- R5: Dedicated capture registers are read-only: bus writes to them have no effect.
- R6: Each compare channel j (register at address 12+j) has a 2-bit action field at bits [2j+1:2j] of address 3, coded 00 none, 01 toggle, 10 drive low, 11 drive high. In a clock in which the counter runs and equals the register, flag bit 4+j is set and the action is applied to `cmp_out[j]`.
- R7: The shared channel (register at address 11) follows control bit 1. When the bit is 0 it is compare channel 4: action field bits [9:8], flag bit 8, pin `sh_out`, `sh_oe` high, and the register is writable. When the bit is 1 it is capture channel 3: edge field bits [7:6], flag bit 3, pin `sh_in`, `sh_oe` low, and bus writes to the register are ignored.
- R8: Writing a 1 to a bit of the flag register (address 4) clears that bit and leaves the other bits unchanged. If an event sets a flag in the same clock as its clear, the flag stays set.
- R9: `bus_rdata` is registered and shows the register at `bus_addr` one clock later. Unmapped addresses (5 to 7) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cap_in | input | 3 | Dedicated capture pins |
| cmp_out | output | 4 | Dedicated compare pins |
| sh_in | input | 1 | Shared channel input pin |
| sh_out | output | 1 | Shared channel output pin |
| sh_oe | output | 1 | Shared channel output enable |

## Verification
A corrupted counter shows on the very next read of address 0. It also surfaces as a wrong value latched by the next capture, because the bench freezes the counter and expects the frozen value in the capture register. A wrong edge decode, or a mis-gated shared channel, leaves a flag bit or register off within five clocks of the pin change. A wrong compare state or action shows on the pins within a clock of the match. Because the bench reads the flag register only after the pins settle, a lost or sticky flag is caught at the next read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_ANY} edge_sel_t;
  typedef enum logic [1:0] {ACT_NONE, ACT_TOGGLE, ACT_LOW, ACT_HIGH} pin_act_t;

  localparam logic [3:0] ADR_COUNT  = 4'd0;
  localparam logic [3:0] ADR_CTRL   = 4'd1;
  localparam logic [3:0] ADR_EDGES  = 4'd2;
  localparam logic [3:0] ADR_ACTS   = 4'd3;
  localparam logic [3:0] ADR_FLAGS  = 4'd4;
  localparam logic [3:0] ADR_CAP0   = 4'd8;
  localparam logic [3:0] ADR_SHARED = 4'd11;
  localparam logic [3:0] ADR_CMP0   = 4'd12;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (run) count <= count + 1'b1;
  end

  assign wrap = run && (&count);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count));
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      pin,
  input  edge_sel_t sel,
  output logic      evt
);
  logic sync1, sync2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= pin;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_comb begin
    case (sel)
      EDGE_RISE: evt = en && sync2 && !prev;
      EDGE_FALL: evt = en && !sync2 && prev;
      EDGE_ANY:  evt = en && (sync2 ^ prev);
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_cmp_pin.sv
module tmr_cmp_pin
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] match_val,
  input  pin_act_t         act,
  output logic             evt,
  output logic             pin
);
  assign evt = en && run && (count == match_val);

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else if (evt) begin
      case (act)
        ACT_TOGGLE: pin <= !pin;
        ACT_LOW:    pin <= 1'b0;
        ACT_HIGH:   pin <= 1'b1;
        default:    pin <= pin;
      endcase
    end
  end

  a_r6_drive_high: assert property (@(posedge clk) disable iff (rst)
    (evt && act == ACT_HIGH) |=> pin);
  a_r6_no_match_hold: assert property (@(posedge clk) disable iff (rst)
    !evt |=> $stable(pin));
endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_IC  = 3,
  parameter int N_OC  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic [N_IC-1:0]  cap_in,
  output logic [N_OC-1:0]  cmp_out,
  input  logic             sh_in,
  output logic             sh_out,
  output logic             sh_oe
);
  localparam int NCAP    = N_IC + 1;
  localparam int NCMP    = N_OC + 1;
  localparam int FL_CMP0 = NCAP;
  localparam int FL_OVF  = CNT_W - 1;

  logic                 run_q, mode_q;
  logic [2*NCAP-1:0]    edge_q;
  logic [2*NCMP-1:0]    act_q;
  logic [CNT_W-1:0]     flag_q, flag_set, flag_clr;
  logic [CNT_W-1:0]     cap_q [N_IC];
  logic [CNT_W-1:0]     cmp_q [N_OC];
  logic [CNT_W-1:0]     sh_q;
  logic [CNT_W-1:0]     cmp_match [NCMP];
  logic [CNT_W-1:0]     count;
  logic [CNT_W-1:0]     rd_mux;
  logic                 wrap;
  logic [NCAP-1:0]      cap_hit;
  logic [NCMP-1:0]      cmp_hit;
  logic [NCMP-1:0]      pin_w;
  logic [NCAP-1:0]      pins_all;

  assign pins_all = {sh_in, cap_in};

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .count(count), .wrap(wrap)
  );

  for (genvar k = 0; k < NCAP; k++) begin : g_cap
    tmr_edge_det u_det (
      .clk(clk), .rst(rst),
      .en((k < N_IC) ? 1'b1 : mode_q),
      .pin(pins_all[k]),
      .sel(edge_sel_t'(edge_q[2*k +: 2])),
      .evt(cap_hit[k])
    );
  end

  always_comb begin
    for (int j = 0; j < N_OC; j++) cmp_match[j] = cmp_q[j];
    cmp_match[N_OC] = sh_q;
  end

  for (genvar j = 0; j < NCMP; j++) begin : g_cmp
    tmr_cmp_pin #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst(rst),
      .en((j < N_OC) ? 1'b1 : !mode_q),
      .run(run_q), .count(count), .match_val(cmp_match[j]),
      .act(pin_act_t'(act_q[2*j +: 2])),
      .evt(cmp_hit[j]), .pin(pin_w[j])
    );
  end

  assign cmp_out = pin_w[N_OC-1:0];
  assign sh_out  = pin_w[N_OC];

  // control, edge and action registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      edge_q <= '0;
      act_q  <= '0;
      sh_oe  <= 1'b1;
    end else begin
      sh_oe <= !mode_q;
      if (bus_we && bus_addr == ADR_CTRL) begin
        run_q  <= bus_wdata[0];
        mode_q <= bus_wdata[1];
      end
      if (bus_we && bus_addr == ADR_EDGES) edge_q <= bus_wdata[2*NCAP-1:0];
      if (bus_we && bus_addr == ADR_ACTS)  act_q  <= bus_wdata[2*NCMP-1:0];
    end
  end

  // capture and compare value registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_IC; k++) cap_q[k] <= '1;
      for (int j = 0; j < N_OC; j++) cmp_q[j] <= '1;
      sh_q <= '1;
    end else begin
      for (int k = 0; k < N_IC; k++)
        if (cap_hit[k]) cap_q[k] <= count;
      for (int j = 0; j < N_OC; j++)
        if (bus_we && bus_addr == 4'(ADR_CMP0 + j)) cmp_q[j] <= bus_wdata;
      if (cap_hit[N_IC])
        sh_q <= count;
      else if (!mode_q && bus_we && bus_addr == ADR_SHARED)
        sh_q <= bus_wdata;
    end
  end

  // flags: event set has priority over write-one clear
  always_comb begin
    flag_set = '0;
    for (int k = 0; k < NCAP; k++) flag_set[k] = cap_hit[k];
    for (int j = 0; j < NCMP; j++) flag_set[FL_CMP0 + j] = cmp_hit[j];
    flag_set[FL_OVF] = wrap;
    flag_clr = (bus_we && bus_addr == ADR_FLAGS) ? bus_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  // registered read path
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADR_COUNT:  rd_mux = count;
      ADR_CTRL:   rd_mux = CNT_W'({mode_q, run_q});
      ADR_EDGES:  rd_mux = CNT_W'(edge_q);
      ADR_ACTS:   rd_mux = CNT_W'(act_q);
      ADR_FLAGS:  rd_mux = flag_q;
      ADR_SHARED: rd_mux = sh_q;
      default:    rd_mux = '0;
    endcase
    for (int k = 0; k < N_IC; k++)
      if (bus_addr == 4'(ADR_CAP0 + k)) rd_mux = cap_q[k];
    for (int j = 0; j < N_OC; j++)
      if (bus_addr == 4'(ADR_CMP0 + j)) rd_mux = cmp_q[j];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q[FL_OVF]);
  a_r4_cap_loads: assert property (@(posedge clk) disable iff (rst)
    cap_hit[0] |=> cap_q[0] == $past(count));
  a_r5_cap_hold: assert property (@(posedge clk) disable iff (rst)
    !cap_hit[0] |=> $stable(cap_q[0]));
  a_r7_shared_oe: assert property (@(posedge clk) disable iff (rst)
    mode_q |=> !sh_oe);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    cap_hit[0] |=> flag_q[0]);
endmodule

// File: tb/tmr_ccu_tb.sv
module tmr_ccu_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [2:0]  cap_in;
  logic [3:0]  cmp_out;
  logic        sh_in, sh_out, sh_oe;
  int          errs = 0;
  int          checks = 0;

  always #2 clk = !clk;

  tmr_ccu u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .cmp_out(cmp_out), .sh_in(sh_in), .sh_out(sh_out), .sh_oe(sh_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(4'd0, v);  chk("R1 counter", v, 16'h0000);
    for (int k = 8; k < 16; k++) begin
      rd(4'(k), v); chk("R1 capture/compare reg", v, 16'hFFFF);
    end
    rd(4'd4, v);  chk("R1 flags", v, 16'h0000);
    chk("R1 cmp_out", cmp_out, 4'b0000);
    chk("R1 sh_oe", sh_oe, 1'b1);
    for (int k = 5; k < 8; k++) begin
      rd(4'(k), v); chk("R9 unmapped", v, 16'h0000);
    end
  endtask

  task automatic t_counter();
    logic [15:0] c0, c1;
    rd(4'd0, c0);
    wr(4'd1, 16'h0001);
    repeat (10) @(negedge clk);
    wr(4'd1, 16'h0000);
    rd(4'd0, c1); chk("R2 counts 12 clocks", c1, c0 + 16'd12);
    repeat (6) @(negedge clk);
    rd(4'd0, c0); chk("R2 holds when stopped", c0, c1);
    wr(4'd0, 16'h1234);
    rd(4'd0, c0); chk("R2 write ignored", c0, c1);
  endtask

  task automatic t_capture();
    logic [15:0] v, v2, d;
    rd(4'd0, v);
    wr(4'd2, 16'h0039);          // ch0 rise, ch1 fall, ch2 any
    wr(4'd4, 16'hFFFF);
    @(negedge clk) cap_in = 3'b111;
    repeat (5) @(negedge clk);
    rd(4'd8, d);  chk("R4 rise captured", d, v);
    rd(4'd9, d);  chk("R4 fall ignores rise", d, 16'hFFFF);
    rd(4'd10, d); chk("R4 any on rise", d, v);
    rd(4'd4, d);  chk("R4 flags rise", d, 16'h0005);
    wr(4'd4, 16'hFFFF);
    wr(4'd1, 16'h0001);
    repeat (7) @(negedge clk);
    wr(4'd1, 16'h0000);
    rd(4'd0, v2);
    @(negedge clk) cap_in = 3'b000;
    repeat (5) @(negedge clk);
    rd(4'd8, d);  chk("R4 rise ignores fall", d, v);
    rd(4'd9, d);  chk("R4 fall captured", d, v2);
    rd(4'd10, d); chk("R4 any on fall", d, v2);
    rd(4'd4, d);  chk("R4 flags fall", d, 16'h0006);
    wr(4'd8, 16'h1234);
    rd(4'd8, d);  chk("R5 capture read-only", d, v);
    wr(4'd2, 16'h0000);
    wr(4'd4, 16'hFFFF);
    @(negedge clk) cap_in = 3'b111;
    repeat (5) @(negedge clk);
    rd(4'd4, d);  chk("R4 disabled no flag", d, 16'h0000);
    @(negedge clk) cap_in = 3'b000;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    wr(4'd2, 16'h0001);
    wr(4'd4, 16'hFFFF);
    @(negedge clk) cap_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd4; bus_wdata = 16'h0001;
    @(negedge clk);
    bus_we = 1'b0;
    rd(4'd4, d);  chk("R8 set wins over clear", d, 16'h0001);
    wr(4'd4, 16'h0001);
    rd(4'd4, d);  chk("R8 write-one clears", d, 16'h0000);
    @(negedge clk) cap_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    wr(4'd2, 16'h0000);
    wr(4'd4, 16'hFFFF);
  endtask

  task automatic cmp_pass(input logic [15:0] acts);
    logic [15:0] v, d;
    rd(4'd0, v);
    for (int j = 12; j < 16; j++) wr(4'(j), v + 16'd20);
    wr(4'd11, v + 16'd20);
    wr(4'd3, acts);
    wr(4'd4, 16'hFFFF);
    wr(4'd1, 16'h0001);
    rd(4'd4, d);  chk("R6 no flag before match", d, 16'h0000);
    repeat (40) @(negedge clk);
    wr(4'd1, 16'h0000);
    rd(4'd4, d);  chk("R6/R7 compare flags", d, 16'h01F0);
  endtask

  task automatic t_compare();
    cmp_pass(16'h033D);   // ch0 tog, ch1 high, ch2 high, ch3 none, shared high
    chk("R6 pins pass1", cmp_out, 4'b0111);
    chk("R7 sh_out high", sh_out, 1'b1);
    cmp_pass(16'h02C9);   // ch0 tog, ch1 low, ch2 none, ch3 high, shared low
    chk("R6 pins pass2", cmp_out, 4'b1100);
    chk("R7 sh_out low", sh_out, 1'b0);
  endtask

  task automatic t_shared_cap();
    logic [15:0] s0, v, d;
    wr(4'd1, 16'h0002);
    repeat (2) @(negedge clk);
    chk("R7 sh_oe low in capture", sh_oe, 1'b0);
    wr(4'd2, 16'h0040);
    wr(4'd4, 16'hFFFF);
    rd(4'd11, s0);
    wr(4'd11, 16'h1234);
    rd(4'd11, d); chk("R7 shared write ignored", d, s0);
    rd(4'd0, v);
    @(negedge clk) sh_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'd11, d); chk("R7 shared captured", d, v);
    rd(4'd4, d);  chk("R7 shared flag bit3", d, 16'h0008);
    wr(4'd1, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R7 sh_oe high in compare", sh_oe, 1'b1);
    wr(4'd2, 16'h0000);
  endtask

  task automatic t_overflow();
    logic [15:0] d, f1;
    wr(4'd4, 16'hFFFF);
    rd(4'd4, d);  chk("R3 no overflow yet", d[15], 1'b0);
    wr(4'd1, 16'h0001);
    repeat (65600) @(negedge clk);
    wr(4'd1, 16'h0000);
    rd(4'd4, f1); chk("R3 overflow flag", f1[15], 1'b1);
    rd(4'd0, d);  chk("R3 counter wrapped", d < 16'd200, 1'b1);
    wr(4'd4, 16'h8000);
    rd(4'd4, d);  chk("R8 partial clear", d, f1 & 16'h7FFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    cap_in = '0; sh_in = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_counter();
    t_capture();
    t_set_wins();
    t_compare();
    t_shared_cap();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule